// File: doc/BRIEF.md
# PRBS23 Payload Sync and Error Checker

This block watches a byte stream of transport packets and checks a pseudo-random test pattern carried inside the packet payload. Each byte comes with a start-of-packet flag. A byte with that flag set is the packet's sync byte. The checker treats it as if it were absent: the byte neither feeds the local generator nor gets compared. Every other accepted byte is a payload byte, and payload bytes carry one continuous 2^23−1 sequence built from the recurrence b[n] = b[n−23] xor b[n−18], which corresponds to the polynomial x^23 + x^18 + 1.

After reset the checker fills its 23-bit generator directly from received payload bits. It then runs the generator on its own and compares each following byte against the prediction. Once enough bytes have matched, it raises a sync flag. From then on it emits one error mask per payload byte. Each mask is the bitwise XOR of the received byte and the predicted byte, so every set bit marks one bit error. A downstream saturating counter adds up the masks. If errors become too dense, the checker drops sync and fills the generator again.

Input and output both use valid/ready. An input byte is taken on a cycle where `s_valid` and `s_ready` are both high. `s_ready` is high whenever the output register is empty or is being drained in the same cycle. An output mask, once valid, stays valid and unchanged until `m_ready` is high.

Top module: `prbs23_payload_checker`

## Requirements
- R1: After reset, `sync_o` is low, `m_valid` is low and `s_ready` is high.
- R2: Bits within a byte are taken MSB first. The generator is filled from three consecutive payload bytes, and of those 24 bits it keeps the last 23. Each predicted bit equals the bit 23 positions earlier XOR the bit 18 positions earlier.
- R3: An accepted byte with `s_sop` high produces no mask. It does not advance the generator and does not count toward fill, verification or the loss window.
- R4: After the fill, 8 consecutive error-free payload bytes (64 correctly predicted bits) raise `sync_o`. From reset with a clean stream, `sync_o` goes high on the edge that takes the 11th payload byte.
- R5: If a verification byte has any mismatching bit, that byte is discarded and the fill restarts with the next payload byte.
- R6: A mask is produced only for a payload byte that is accepted while `sync_o` is already high. The mask equals received byte XOR predicted byte, and it appears one cycle after the byte is taken.
- R7: While in sync, the checker sums the set bits of the masks for the last 8 payload bytes. If that sum exceeds 16, `sync_o` falls and the fill restarts. A sum of exactly 16 keeps sync. The window empties whenever sync is not held.
- R8: If a completed fill leaves the generator all zero, the checker does not enter verification and starts a new fill, so a stream of zero bytes never gains sync.
- R9: While `m_valid` is high and `m_ready` is low, `s_ready` is low and `m_mask` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Checker can take a byte |
| s_sop | input | 1 | Byte is the packet sync byte |
| s_data | input | 8 | Received byte |
| m_valid | output | 1 | Error mask valid |
| m_ready | input | 1 | Consumer takes the mask |
| m_mask | output | 8 | Per-bit error mask (1 = bit error) |
| sync_o | output | 1 | Checker is synchronized |

## Verification
The bench computes its reference sequence from the recurrence and uses it to build four kinds of stream, each aimed at one behaviour.

- A clean stream with sync bytes inserted shows the exact byte on which lock occurs, and that sync bytes are skipped.
- Sparse single-bit corruptions, at known bit positions, check that each mask bit lines up with the corrupted bit.
- Bursts of fully inverted bytes find the boundary between a window sum of 16, which keeps sync, and 24, which drops it.
- A corruption during verification, and a stream of all-zero bytes, show apart a restarted fill from a lock that should not happen.

A stalled output is also held while an input byte waits, to confirm that nothing is lost or overwritten.

// File: rtl/prbs23_pkg.sv
package prbs23_pkg;
  localparam int PRBS_W = 23;
  localparam int PRBS_TAP = 18;

  typedef enum logic [1:0] {
    ST_FILL   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCK   = 2'd2
  } chk_state_e;
endpackage

// File: rtl/prbs23_byte_step.sv
// Advances the generator by one byte worth of steps, MSB first.
// In fill mode the received bits are shifted in; otherwise the
// generator runs on its own predictions.
module prbs23_byte_step #(
  parameter int W = 23,
  parameter int TAP = 18,
  parameter int N = 8
) (
  input  logic [W-1:0] seed,
  input  logic [N-1:0] din,
  input  logic         fill,
  output logic [W-1:0] next,
  output logic [N-1:0] pred
);
  logic [W-1:0] chain [N+1];

  assign chain[0] = seed;

  for (genvar k = 0; k < N; k++) begin : g_bit
    logic p;
    logic b;
    assign p = chain[k][W-1] ^ chain[k][TAP-1];
    assign b = fill ? din[N-1-k] : p;
    assign pred[N-1-k] = p;
    assign chain[k+1] = {chain[k][W-2:0], b};
  end

  assign next = chain[N];
endmodule

// File: rtl/prbs23_err_window.sv
// Sliding sum of error bits over the last DEPTH masked bytes.
module prbs23_err_window #(
  parameter int DEPTH = 8,
  parameter int BYTE_W = 8,
  parameter int LIMIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [BYTE_W-1:0] mask,
  output logic              over
);
  localparam int CW = $clog2(BYTE_W + 1);
  localparam int SW = $clog2(DEPTH * BYTE_W + 1);

  logic [CW-1:0] hist_q [DEPTH];
  logic [CW-1:0] ones;
  logic [SW-1:0] sum_q;
  logic [SW-1:0] sum_new;

  always_comb begin
    ones = '0;
    for (int i = 0; i < BYTE_W; i++) begin
      ones = ones + CW'(mask[i]);
    end
    sum_new = sum_q + SW'(ones) - SW'(hist_q[DEPTH-1]);
    over = push && (sum_new > SW'(LIMIT));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      sum_q <= '0;
    end else if (push) begin
      sum_q <= sum_new;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_hist
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n || clr) hist_q[g] <= '0;
        else if (push)     hist_q[g] <= ones;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rst_n || clr) hist_q[g] <= '0;
        else if (push)     hist_q[g] <= hist_q[g-1];
      end
    end
  end

  p_sum_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sum_q <= SW'(DEPTH * BYTE_W));

  p_clr_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> sum_q == '0);
endmodule

// File: rtl/prbs23_payload_checker.sv
module prbs23_payload_checker
  import prbs23_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LOCK_BITS = 64,
  parameter int WIN_BITS = 64,
  parameter int LOSS_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic              s_sop,
  input  logic [BYTE_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [BYTE_W-1:0] m_mask,
  output logic              sync_o
);
  localparam int FILL_BYTES = (PRBS_W + BYTE_W - 1) / BYTE_W;
  localparam int LOCK_BYTES = LOCK_BITS / BYTE_W;
  localparam int WIN_BYTES = WIN_BITS / BYTE_W;
  localparam int CNT_W = $clog2(FILL_BYTES + LOCK_BYTES + 1);

  chk_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PRBS_W-1:0] gen_q, gen_d, step_next;
  logic [BYTE_W-1:0] step_pred, byte_err;
  logic              accept, pay, win_over;

  assign s_ready = !m_valid || m_ready;
  assign accept = s_valid && s_ready;
  assign pay = accept && !s_sop;
  assign sync_o = (st_q == ST_LOCK);
  assign byte_err = s_data ^ step_pred;

  prbs23_byte_step #(.W(PRBS_W), .TAP(PRBS_TAP), .N(BYTE_W)) u_step (
    .seed (gen_q),
    .din  (s_data),
    .fill (st_q == ST_FILL),
    .next (step_next),
    .pred (step_pred)
  );

  prbs23_err_window #(.DEPTH(WIN_BYTES), .BYTE_W(BYTE_W), .LIMIT(LOSS_LIMIT)) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st_q != ST_LOCK),
    .push  (pay && st_q == ST_LOCK),
    .mask  (byte_err),
    .over  (win_over)
  );

  always_comb begin
    st_d = st_q;
    cnt_d = cnt_q;
    gen_d = gen_q;
    if (pay) begin
      gen_d = step_next;
      case (st_q)
        ST_FILL: begin
          if (cnt_q == CNT_W'(FILL_BYTES - 1)) begin
            cnt_d = '0;
            if (step_next != '0) st_d = ST_VERIFY;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_VERIFY: begin
          if (byte_err != '0) begin
            st_d = ST_FILL;
            cnt_d = '0;
          end else if (cnt_q == CNT_W'(LOCK_BYTES - 1)) begin
            st_d = ST_LOCK;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          if (win_over) begin
            st_d = ST_FILL;
            cnt_d = '0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_FILL;
      cnt_q <= '0;
      gen_q <= '0;
    end else begin
      st_q <= st_d;
      cnt_q <= cnt_d;
      gen_q <= gen_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_mask <= '0;
    end else if (pay && st_q == ST_LOCK) begin
      m_valid <= 1'b1;
      m_mask <= byte_err;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  p_skip_sop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && s_sop |=> $stable(gen_q) && $stable(cnt_q) && !$rose(m_valid));

  p_mask_needs_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(sync_o));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_mask));

  p_nonzero_gen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != ST_FILL |-> gen_q != '0);

  p_lock_from_verify_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_o) |-> $past(st_q) == ST_VERIFY);
endmodule

// File: tb/sim_prbs23_payload_checker.sv
module sim_prbs23_payload_checker;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic s_sop = 1'b0;
  logic [7:0] s_data = '0;
  logic m_ready = 1'b1;
  logic s_ready, m_valid, sync_o;
  logic [7:0] m_mask;

  int n_checks = 0;
  int n_fail = 0;
  logic [22:0] ref_h = 23'h1;

  always #(CLK_PERIOD/2) clk = ~clk;

  prbs23_payload_checker u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_sop(s_sop), .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready),
    .m_mask(m_mask), .sync_o(sync_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // next reference byte, MSB first: b[n] = b[n-23] ^ b[n-18]
  function automatic logic [7:0] ref_byte();
    logic [7:0] r;
    logic nb;
    for (int i = 7; i >= 0; i--) begin
      nb = ref_h[22] ^ ref_h[17];
      r[i] = nb;
      ref_h = {ref_h[21:0], nb};
    end
    return r;
  endfunction

  task automatic send(input logic [7:0] d, input logic sop);
    @(negedge clk);
    s_valid = 1'b1;
    s_data = d;
    s_sop = sop;
    @(posedge clk);
    #1;
    s_valid = 1'b0;
    s_sop = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    logic [7:0] b, e;
    do_reset();
    #1;
    chk(sync_o == 1'b0, "R1 sync after reset", int'(sync_o), 0);
    chk(m_valid == 1'b0, "R1 m_valid after reset", int'(m_valid), 0);
    chk(s_ready == 1'b1, "R1 s_ready after reset", int'(s_ready), 1);

    // Acquisition on a clean stream with sync bytes interleaved
    send(8'h47, 1'b1);
    chk(m_valid == 1'b0, "R3 no mask for sync byte", int'(m_valid), 0);
    for (int k = 1; k <= 11; k++) begin
      send(ref_byte(), 1'b0);
      if (k == 5) begin
        send(8'h47, 1'b1);
        chk(sync_o == 1'b0 && m_valid == 1'b0, "R3 sync byte skipped in fill/verify",
            int'({sync_o, m_valid}), 0);
      end
      if (k == 10) chk(sync_o == 1'b0, "R4 not locked after 10 payload bytes", int'(sync_o), 0);
      if (k == 11) begin
        chk(sync_o == 1'b1, "R2 R4 locked after 11th payload byte", int'(sync_o), 1);
        chk(m_valid == 1'b0, "R6 no mask for the locking byte", int'(m_valid), 0);
      end
    end

    // Sparse single-bit errors
    for (int i = 0; i < 20; i++) begin
      e = (i % 3 == 0) ? (8'h01 << (i % 8)) : 8'h00;
      b = ref_byte();
      send(b ^ e, 1'b0);
      chk(m_valid == 1'b1 && m_mask == e, "R6 mask equals injected error",
          int'({m_valid, m_mask}), int'({1'b1, e}));
      if (i == 10) begin
        send(8'h47, 1'b1);
        chk(m_valid == 1'b0, "R3 no mask for sync byte while locked", int'(m_valid), 0);
      end
    end

    // Back-pressure
    @(negedge clk);
    @(negedge clk);
    m_ready = 1'b0;
    s_valid = 1'b1;
    s_sop = 1'b0;
    s_data = ref_byte() ^ 8'h80;
    @(posedge clk);
    #1;
    chk(m_valid == 1'b1 && m_mask == 8'h80, "R6 mask under stall", int'(m_mask), 8'h80);
    @(negedge clk);
    s_data = ref_byte() ^ 8'h02;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk);
      #1;
      chk(s_ready == 1'b0 && m_valid == 1'b1 && m_mask == 8'h80, "R9 output held, input stalled",
          int'({s_ready, m_valid, m_mask}), int'({1'b0, 1'b1, 8'h80}));
    end
    @(negedge clk);
    m_ready = 1'b1;
    @(posedge clk);
    #1;
    s_valid = 1'b0;
    chk(m_valid == 1'b1 && m_mask == 8'h02, "R9 stalled byte taken after release",
        int'(m_mask), 8'h02);

    // Loss of sync at the window boundary
    for (int i = 0; i < 8; i++) begin
      send(ref_byte(), 1'b0);
      chk(m_mask == 8'h00, "R6 clean byte gives zero mask", int'(m_mask), 0);
    end
    send(ref_byte() ^ 8'hFF, 1'b0);
    send(ref_byte() ^ 8'hFF, 1'b0);
    chk(sync_o == 1'b1, "R7 window sum 16 keeps sync", int'(sync_o), 1);
    send(ref_byte() ^ 8'hFF, 1'b0);
    chk(m_valid == 1'b1 && m_mask == 8'hFF, "R6 mask of the dropping byte", int'(m_mask), 8'hFF);
    chk(sync_o == 1'b0, "R7 window sum 24 drops sync", int'(sync_o), 0);
    for (int k = 1; k <= 11; k++) begin
      send(ref_byte(), 1'b0);
      if (k == 10) chk(sync_o == 1'b0, "R7 refill before relock", int'(sync_o), 0);
      if (k == 11) chk(sync_o == 1'b1, "R7 relock after refill", int'(sync_o), 1);
    end
    send(ref_byte() ^ 8'hFF, 1'b0);
    send(ref_byte() ^ 8'hFF, 1'b0);
    chk(sync_o == 1'b1, "R7 window empty after relock", int'(sync_o), 1);

    // Error during verification restarts the fill
    do_reset();
    for (int k = 0; k < 6; k++) send(ref_byte(), 1'b0);
    send(ref_byte() ^ 8'h10, 1'b0);
    for (int k = 1; k <= 11; k++) begin
      send(ref_byte(), 1'b0);
      if (k == 10) chk(sync_o == 1'b0, "R5 no lock before new fill completes", int'(sync_o), 0);
      if (k == 11) chk(sync_o == 1'b1, "R5 lock after fresh fill and verify", int'(sync_o), 1);
    end

    // All-zero stream never locks
    do_reset();
    for (int k = 1; k <= 30; k++) begin
      send(8'h00, 1'b0);
      if (k == 11 || k == 30)
        chk(sync_o == 1'b0 && m_valid == 1'b0, "R8 zero fill never locks",
            int'({sync_o, m_valid}), 0);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule